// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads a chip's boot-time configuration from an external serial source once the supply is reported good. It makes a slow mode clock from the system clock and samples one serial bit on each rising edge of that mode clock. The bits are assembled least-significant first into a wide mode word. When the last bit arrives, the word is published and held until power-good falls again.

While loading, the block asks the surrounding reset logic to keep the chip in cold reset, and it drops that request in the cycle the word becomes valid. Two results are derived from the finished word. The first is the effective byte order: a selector bit in the word chooses between an external strap pin and a value bit carried in the stream. The second is an error flag, raised when any of a set of mandatory bits was not loaded as 1.

Top module: `boot_mode_loader`

## Requirements
- R1: While `pwr_ok` is high, `mode_clk` is periodic with a period of DIV system clocks (default 256). It is high for DIV/2 clocks and low for DIV/2 clocks.
- R2: While `pwr_ok` is low, `mode_clk` stays low, `mode_word` reads 0, `load_done` and `mode_err` read 0, and `hold_rst` reads 1. The clock divider and bit counter restart, so the next load begins at bit 0.
- R3: `mode_sdin` is sampled on the system clock edge at which `mode_clk` goes high. Bit k of `mode_word` is the k-th sample taken after loading starts (least-significant bit first).
- R4: `load_done` rises, and `mode_word` takes the loaded value, on the clock edge of the NBITS-th rising edge of `mode_clk`. Before that edge, `load_done` is 0 and `mode_word` is 0.
- R5: After `load_done` is set, `mode_word` and `load_done` do not change, whatever `mode_sdin` does, until `pwr_ok` falls or cold reset is applied.
- R6: `hold_rst` is 1 from reset until loading completes. It goes to 0 on the same edge at which `load_done` rises.
- R7: `big_endian` is registered one cycle behind its sources. When word bit 8 is 0, it follows the `endian_pin` input. When word bit 8 is 1, it equals word bit 9.
- R8: One cycle after `load_done` rises, `mode_err` is 1 if any of word bits 20, 33 or 37 is 0, and 0 otherwise. `mode_err` is 0 whenever `load_done` is 0.
- R9: `cold_rst` is a synchronous active-high reset. Asserting it during a load discards the partial word, so loading restarts from bit 0 once `cold_rst` is released with `pwr_ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| pwr_ok | input | 1 | Supply-good indication; its rising level starts loading |
| mode_sdin | input | 1 | Serial configuration data |
| endian_pin | input | 1 | External byte-order strap |
| mode_clk | output | 1 | Divided clock for the serial source |
| mode_word | output | NBITS | Loaded configuration word |
| load_done | output | 1 | Word complete and frozen |
| big_endian | output | 1 | Effective byte order |
| mode_err | output | 1 | A mandatory bit was loaded as 0 |
| hold_rst | output | 1 | Request to keep cold reset asserted |

## Verification
Bit capture, `load_done`, `hold_rst` and the published word all change on the clock edge at which `mode_clk` rises for the last time. The bench therefore waits for that rising edge and samples on the following falling edge of `clk`. `big_endian` and `mode_err` carry one more register, so they are read one falling edge later. A pin change shows on `big_endian` at the next falling edge after the edge that registers it. The effects of power-good loss and cold reset appear at the first falling edge after the edge that registers them. The bench uses a short divider and word so that many complete loads fit in the run, and it changes serial data only on a falling edge just after each mode-clock rise, which keeps a full mode period of setup.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  localparam int unsigned DEF_DIV     = 256;
  localparam int unsigned DEF_BITS    = 256;
  localparam int unsigned DEF_SEL_BIT = 8;
  localparam int unsigned DEF_VAL_BIT = 9;
  localparam int unsigned DEF_NREQ    = 3;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_SHIFT = 2'd1,
    LD_DONE  = 2'd2
  } load_state_e;
endpackage

// File: rtl/bm_mclk_div.sv
module bm_mclk_div #(
  parameter int unsigned DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mclk,
  output logic rise_stb
);
  localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 2;
  localparam int unsigned HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
      if (cnt_q == MID)       mclk_q <= 1'b1;
      else if (cnt_q == LAST) mclk_q <= 1'b0;
    end
  end

  assign mclk     = mclk_q;
  assign rise_stb = run && !rst && (cnt_q == MID);
endmodule

// File: rtl/bm_shift.sv
module bm_shift
  import boot_mode_pkg::*;
#(
  parameter int unsigned NBITS = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             stb,
  input  logic             sdin,
  output logic [NBITS-1:0] word_o,
  output logic             done_o,
  output logic             hold_o
);
  localparam int unsigned BW = (NBITS > 2) ? $clog2(NBITS) : 2;
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  load_state_e      state_q;
  logic [NBITS-1:0] sh_q;
  logic [NBITS-1:0] word_q;
  logic [BW-1:0]    cnt_q;
  logic             hold_q;
  logic [NBITS-1:0] sh_next;

  assign sh_next = {sdin, sh_q[NBITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state_q <= LD_IDLE;
      sh_q    <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      hold_q  <= 1'b1;
    end else begin
      case (state_q)
        LD_IDLE, LD_SHIFT: begin
          if (stb) begin
            sh_q    <= sh_next;
            state_q <= LD_SHIFT;
            if (cnt_q == LAST_BIT) begin
              word_q  <= sh_next;
              state_q <= LD_DONE;
              hold_q  <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        LD_DONE: begin
          state_q <= LD_DONE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign word_o = word_q;
  assign done_o = (state_q == LD_DONE);
  assign hold_o = hold_q;
endmodule

// File: rtl/bm_mode_eval.sv
module bm_mode_eval #(
  parameter int unsigned NBITS   = 256,
  parameter int unsigned SEL_BIT = 8,
  parameter int unsigned VAL_BIT = 9,
  parameter int unsigned NREQ    = 3,
  parameter int unsigned REQ_POS [NREQ] = '{20, 33, 37}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [NBITS-1:0] word,
  input  logic             done,
  input  logic             pin,
  output logic             endian_o,
  output logic             err_o
);
  logic [NREQ-1:0] miss;
  logic            endian_q;
  logic            err_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    assign miss[g] = ~word[REQ_POS[g]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      endian_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      endian_q <= word[SEL_BIT] ? word[VAL_BIT] : pin;
      err_q    <= run && done && (|miss);
    end
  end

  assign endian_o = endian_q;
  assign err_o    = err_q;
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_mode_pkg::*;
#(
  parameter int unsigned DIV     = DEF_DIV,
  parameter int unsigned NBITS   = DEF_BITS,
  parameter int unsigned SEL_BIT = DEF_SEL_BIT,
  parameter int unsigned VAL_BIT = DEF_VAL_BIT,
  parameter int unsigned NREQ    = DEF_NREQ,
  parameter int unsigned REQ_POS [NREQ] = '{20, 33, 37}
) (
  input  logic             clk,
  input  logic             cold_rst,
  input  logic             pwr_ok,
  input  logic             mode_sdin,
  input  logic             endian_pin,
  output logic             mode_clk,
  output logic [NBITS-1:0] mode_word,
  output logic             load_done,
  output logic             big_endian,
  output logic             mode_err,
  output logic             hold_rst
);
  logic rise_stb;

  bm_mclk_div #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst      (cold_rst),
    .run      (pwr_ok),
    .mclk     (mode_clk),
    .rise_stb (rise_stb)
  );

  bm_shift #(.NBITS(NBITS)) u_shift (
    .clk    (clk),
    .rst    (cold_rst),
    .run    (pwr_ok),
    .stb    (rise_stb),
    .sdin   (mode_sdin),
    .word_o (mode_word),
    .done_o (load_done),
    .hold_o (hold_rst)
  );

  bm_mode_eval #(
    .NBITS   (NBITS),
    .SEL_BIT (SEL_BIT),
    .VAL_BIT (VAL_BIT),
    .NREQ    (NREQ),
    .REQ_POS (REQ_POS)
  ) u_eval (
    .clk      (clk),
    .rst      (cold_rst),
    .run      (pwr_ok),
    .word     (mode_word),
    .done     (load_done),
    .pin      (endian_pin),
    .endian_o (big_endian),
    .err_o    (mode_err)
  );
endmodule

// File: rtl/boot_mode_loader_sva.sv
module boot_mode_loader_sva #(
  parameter int unsigned NBITS = 256
) (
  input logic             clk,
  input logic             cold_rst,
  input logic             pwr_ok,
  input logic             mode_clk,
  input logic [NBITS-1:0] mode_word,
  input logic             load_done,
  input logic             mode_err,
  input logic             hold_rst
);
  // R2: power loss stops the mode clock low and clears results
  a_r2_off_clears: assert property (@(posedge clk) disable iff (cold_rst)
    !pwr_ok |=> (!mode_clk && !load_done && (mode_word == '0) && hold_rst));

  // R4: completion only coincides with a mode clock rise
  a_r4_done_on_rise: assert property (@(posedge clk) disable iff (cold_rst)
    $rose(load_done) |-> $rose(mode_clk));

  // R5: finished word is frozen while power stays good
  a_r5_frozen: assert property (@(posedge clk) disable iff (cold_rst)
    (load_done && pwr_ok) |=> (load_done && $stable(mode_word)));

  // R6: reset request released exactly with completion
  a_r6_hold_vs_done: assert property (@(posedge clk) disable iff (cold_rst)
    load_done |-> !hold_rst);

  // R8: error only reported for a finished word
  a_r8_err_needs_done: assert property (@(posedge clk) disable iff (cold_rst)
    mode_err |-> $past(load_done));
endmodule

bind boot_mode_loader boot_mode_loader_sva #(.NBITS(NBITS)) u_sva (
  .clk       (clk),
  .cold_rst  (cold_rst),
  .pwr_ok    (pwr_ok),
  .mode_clk  (mode_clk),
  .mode_word (mode_word),
  .load_done (load_done),
  .mode_err  (mode_err),
  .hold_rst  (hold_rst)
);

// File: tb/boot_mode_loader_bench.sv
`timescale 1ns/1ps
module boot_mode_loader_bench;
  localparam int unsigned DIV = 16;
  localparam int unsigned NB  = 64;

  logic          clk = 1'b0;
  logic          cold_rst = 1'b1;
  logic          pwr_ok = 1'b0;
  logic          mode_sdin = 1'b0;
  logic          endian_pin = 1'b0;
  logic          mode_clk;
  logic [NB-1:0] mode_word;
  logic          load_done;
  logic          big_endian;
  logic          mode_err;
  logic          hold_rst;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  boot_mode_loader #(.DIV(DIV), .NBITS(NB)) u_boot_mode_loader (
    .clk        (clk),
    .cold_rst   (cold_rst),
    .pwr_ok     (pwr_ok),
    .mode_sdin  (mode_sdin),
    .endian_pin (endian_pin),
    .mode_clk   (mode_clk),
    .mode_word  (mode_word),
    .load_done  (load_done),
    .big_endian (big_endian),
    .mode_err   (mode_err),
    .hold_rst   (hold_rst)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_word(input logic sel, input logic val);
    logic [63:0] w;
    w = 64'h5A3C_96E1_0F7B_C4D2;
    w[8] = sel;
    w[9] = val;
    w[20] = 1'b1;
    w[33] = 1'b1;
    w[37] = 1'b1;
    return w;
  endfunction

  // Feeds bits 1..NB-1 after each mode clock rise; bit 0 must already be on sdin.
  task automatic feed(input logic [63:0] w);
    for (int i = 0; i < NB; i++) begin
      @(posedge mode_clk);
      @(negedge clk);
      if (i == NB - 2) begin
        chk("R4 done not early", 64'(load_done), 64'd0);
        chk("R4 word zero while loading", mode_word, 64'd0);
        chk("R8 err low while loading", 64'(mode_err), 64'd0);
      end
      if (i < NB - 1) mode_sdin = w[i+1];
    end
    chk("R4 done at last rise", 64'(load_done), 64'd1);
    chk("R3 word lsb first", mode_word, w);
    chk("R6 hold released", 64'(hold_rst), 64'd0);
  endtask

  task automatic do_load(input logic [63:0] w);
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    mode_sdin = w[0];
    pwr_ok = 1'b1;
    feed(w);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 reset mode_clk", 64'(mode_clk), 64'd0);
    chk("R9 reset word", mode_word, 64'd0);
    chk("R9 reset done", 64'(load_done), 64'd0);
    chk("R9 reset err", 64'(mode_err), 64'd0);
    chk("R6 reset hold", 64'(hold_rst), 64'd1);
    cold_rst = 1'b0;
  endtask

  task automatic t_idle;
    int rises = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (mode_clk) rises++;
    end
    chk("R2 no mode clock without power", 64'(rises), 64'd0);
  endtask

  task automatic t_shape;
    int hi = 0;
    int lo = 0;
    @(negedge clk);
    pwr_ok = 1'b1;
    while (!mode_clk) @(negedge clk);
    while (mode_clk) begin hi++; @(negedge clk); end
    while (!mode_clk) begin lo++; @(negedge clk); end
    chk("R1 mode clock high time", 64'(hi), 64'(DIV / 2));
    chk("R1 mode clock low time", 64'(lo), 64'(DIV / 2));
    pwr_ok = 1'b0;
  endtask

  task automatic t_pin_load;
    logic [63:0] w;
    w = mk_word(1'b0, 1'b0);
    endian_pin = 1'b1;
    do_load(w);
    @(negedge clk);
    chk("R8 no err all mandatory set", 64'(mode_err), 64'd0);
    chk("R7 endian from pin high", 64'(big_endian), 64'd1);
    endian_pin = 1'b0;
    @(negedge clk);
    chk("R7 endian follows pin low", 64'(big_endian), 64'd0);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      mode_sdin = ~mode_sdin;
    end
    chk("R5 word frozen", mode_word, w);
    chk("R5 done held", 64'(load_done), 64'd1);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R2 drop clears word", mode_word, 64'd0);
    chk("R2 drop clears done", 64'(load_done), 64'd0);
    chk("R2 drop stops mode clock", 64'(mode_clk), 64'd0);
    chk("R2 drop raises hold", 64'(hold_rst), 64'd1);
    chk("R2 drop clears err", 64'(mode_err), 64'd0);
  endtask

  task automatic t_stream_endian;
    logic [63:0] w;
    w = mk_word(1'b1, 1'b1);
    endian_pin = 1'b0;
    do_load(w);
    @(negedge clk);
    chk("R7 endian from stream bit", 64'(big_endian), 64'd1);
    chk("R8 no err stream case", 64'(mode_err), 64'd0);
    endian_pin = 1'b1;
    w = mk_word(1'b1, 1'b0);
    do_load(w);
    @(negedge clk);
    chk("R7 stream overrides pin", 64'(big_endian), 64'd0);
  endtask

  task automatic t_missing;
    int pos [3] = '{20, 33, 37};
    for (int j = 0; j < 3; j++) begin
      logic [63:0] w;
      w = mk_word(1'b0, 1'b0);
      w[pos[j]] = 1'b0;
      do_load(w);
      chk("R8 done before err", 64'(mode_err), 64'd0);
      @(negedge clk);
      chk("R8 err on missing mandatory bit", 64'(mode_err), 64'd1);
    end
  endtask

  task automatic t_abort;
    logic [63:0] w;
    w = mk_word(1'b0, 1'b1);
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    mode_sdin = 1'b1;
    pwr_ok = 1'b1;
    repeat (3) @(posedge mode_clk);
    @(negedge clk);
    cold_rst = 1'b1;
    @(negedge clk);
    chk("R9 abort clears word", mode_word, 64'd0);
    chk("R9 abort clears done", 64'(load_done), 64'd0);
    chk("R9 abort stops mode clock", 64'(mode_clk), 64'd0);
    cold_rst = 1'b0;
    mode_sdin = w[0];
    feed(w);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_shape();
    t_pin_load();
    t_stream_endian();
    t_missing();
    t_abort();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule